// File: doc/BRIEF.md
# Bit-Addressable I/O Register Space

This block holds the peripheral register file of a small 8-bit processor and answers three kinds of access to it. A port-style path carries a 6-bit I/O address, but its address pin is a full byte so that an out-of-range request can be detected. A load/store path uses the 8-bit data-space map, in which every I/O register appears 0x20 above its I/O address. A bit path performs single-bit set, clear and test on the low 32 I/O locations.

The register file has three general-purpose byte registers and one status register. The status flags are set by hardware pulses and cleared by software writing a one. Bit set and bit clear operations touch only the named bit, so the other pending flags survive.

Every access finishes in the cycle it is presented. Nothing is buffered and there is no back-pressure, so the pins are plain strobes rather than a valid/ready handshake. Read data and the bit-test result are combinational. Writes take effect at the next rising clock edge.

Top module: `io_regspace`

## Requirements
- R1: A port access with `port_addr` in 0x00..0x3F reads the register at that I/O address on `port_rdata` in the same cycle. When `port_we` is 1, it writes `port_wdata` at the next edge.
- R2: A load/store access with `ds_addr` in 0x20..0x5F reaches the register at I/O address `ds_addr - 0x20`. It reads on `ds_rdata` and writes `ds_wdata` when `ds_we` is 1.
- R3: Load/store addresses 0x00..0x1F and 0x60..0xFF, and I/O addresses with no register, return 0x00 and ignore writes. Every read output is 0x00 while its path is idle.
- R4: A port access with `port_addr` of 0x40 or above changes no register, returns 0x00 and raises `acc_err` in the same cycle.
- R5: On an I/O address below 0x20, `bit_op` = 2'b00 (set) and `bit_op` = 2'b01 (clear) change only bit `bit_idx` of the target register. Codes 2'b10 and 2'b11 only test the bit.
- R6: A bit operation with `bit_addr` of 0x20 or above writes nothing, drives `bit_val` to 0 and raises `acc_err` in the same cycle.
- R7: While `bit_en` is 1 and `bit_addr` is below 0x20, `bit_val` shows bit `bit_idx` of the addressed register in the same cycle.
- R8: The three general-purpose registers sit at I/O addresses 0x08, 0x09 and 0x0A. All their bits are read/write and they reset to 0x00.
- R9: The status register sits at I/O address 0x0C and resets to 0x00. A byte write clears each flag written with a one and leaves flags written with a zero. A bit set clears only the named flag. A bit clear leaves it unchanged.
- R10: A one on `flag_set[i]` sets status flag i at the next edge. This set wins over a clear of the same flag in the same cycle.
- R11: When writes arrive on several paths in the same cycle, only one is performed. A legal bit set or clear goes first, then a port write, then a load/store write. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port-style access strobe |
| port_we | input | 1 | Port-style write (1) or read (0) |
| port_addr | input | 8 | Port-style I/O address, legal 0x00..0x3F |
| port_wdata | input | 8 | Port-style write data |
| port_rdata | output | 8 | Port-style read data |
| ds_en | input | 1 | Load/store access strobe |
| ds_we | input | 1 | Load/store write (1) or read (0) |
| ds_addr | input | 8 | Data-space address |
| ds_wdata | input | 8 | Load/store write data |
| ds_rdata | output | 8 | Load/store read data |
| bit_en | input | 1 | Bit operation strobe |
| bit_op | input | 2 | 00 set, 01 clear, 10/11 test |
| bit_addr | input | 6 | Bit-path I/O address, legal 0x00..0x1F |
| bit_idx | input | 3 | Bit index within the register |
| bit_val | output | 1 | Value of the addressed bit |
| flag_set | input | 8 | Hardware set pulses for the status flags |
| acc_err | output | 1 | Out-of-range port or bit access this cycle |

## Verification
Software clears and hardware sets of the status flags can fall in the same cycle. A bit write and a byte write on another path can also coincide. Directed steps raise `flag_set` together with byte writes and with bit-set operations on the same flag. Further steps issue port, load/store and bit writes in one cycle to the same register. A randomized phase mixes all inputs freely. A behavioural model in the bench, holding plain integers, predicts every read output, `bit_val` and `acc_err` for every cycle. After each edge it applies the R10 set-wins rule and the R11 priority order.

// File: rtl/io_rs_pkg.sv
package io_rs_pkg;
  localparam logic [5:0] GP_BASE    = 6'h08;
  localparam logic [5:0] ST_ADDR    = 6'h0C;
  localparam logic [7:0] DS_OFFSET  = 8'h20;
  localparam logic [7:0] DS_IO_END  = 8'h60;
  localparam int         IO_SPAN    = 64;
  localparam int         BIT_SPAN   = 32;

  typedef enum logic [1:0] {
    BOP_SET  = 2'b00,
    BOP_CLR  = 2'b01,
    BOP_TST  = 2'b10,
    BOP_TST2 = 2'b11
  } bit_op_e;
endpackage

// File: rtl/io_rs_decode.sv
module io_rs_decode
  import io_rs_pkg::*;
#(
  parameter int NGP = 3
) (
  input  logic            hit,
  input  logic [5:0]      io_addr,
  output logic [NGP:0]    sel
);
  always_comb begin
    sel = '0;
    for (int i = 0; i < NGP; i++) begin
      if (hit && io_addr == GP_BASE + 6'(i)) sel[i] = 1'b1;
    end
    if (hit && io_addr == ST_ADDR) sel[NGP] = 1'b1;
  end
endmodule

// File: rtl/io_rs_gpreg.sv
module io_rs_gpreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] val,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= (q & ~mask) | (val & mask);
  end
endmodule

// File: rtl/io_rs_w1c.sv
module io_rs_w1c #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] hw_set,
  output logic [DW-1:0] q
);
  logic [DW-1:0] clr;
  assign clr = we ? (mask & val) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | hw_set;
  end
endmodule

// File: rtl/io_regspace.sv
module io_regspace
  import io_rs_pkg::*;
#(
  parameter int NGP = 3,
  parameter int DW  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  port_en,
  input  logic                  port_we,
  input  logic [7:0]            port_addr,
  input  logic [DW-1:0]         port_wdata,
  output logic [DW-1:0]         port_rdata,
  input  logic                  ds_en,
  input  logic                  ds_we,
  input  logic [7:0]            ds_addr,
  input  logic [DW-1:0]         ds_wdata,
  output logic [DW-1:0]         ds_rdata,
  input  logic                  bit_en,
  input  logic [1:0]            bit_op,
  input  logic [5:0]            bit_addr,
  input  logic [$clog2(DW)-1:0] bit_idx,
  output logic                  bit_val,
  input  logic [DW-1:0]         flag_set,
  output logic                  acc_err
);
  localparam int NSLOT = NGP + 1;

  logic             port_ok, port_bad, ds_io, bit_ok, bit_bad, bit_wr;
  logic [7:0]       ds_off;
  logic [NSLOT-1:0] sel_port, sel_ds, sel_bit, wr_sel;
  logic [DW-1:0]    wr_mask, wr_val, bit_byte;
  logic [DW-1:0]    slot_q [NSLOT];
  logic [NGP*DW-1:0] gp_flat;
  logic [DW-1:0]    st_q;

  assign port_ok  = port_en && (port_addr < 8'(IO_SPAN));
  assign port_bad = port_en && !port_ok;
  assign ds_io    = ds_en && (ds_addr >= DS_OFFSET) && (ds_addr < DS_IO_END);
  assign ds_off   = ds_addr - DS_OFFSET;
  assign bit_ok   = bit_en && (bit_addr < 6'(BIT_SPAN));
  assign bit_bad  = bit_en && !bit_ok;
  assign bit_wr   = bit_ok && (bit_op == BOP_SET || bit_op == BOP_CLR);
  assign acc_err  = port_bad || bit_bad;

  io_rs_decode #(.NGP(NGP)) u_dec_port (.hit(port_ok), .io_addr(port_addr[5:0]), .sel(sel_port));
  io_rs_decode #(.NGP(NGP)) u_dec_ds   (.hit(ds_io),   .io_addr(ds_off[5:0]),    .sel(sel_ds));
  io_rs_decode #(.NGP(NGP)) u_dec_bit  (.hit(bit_ok),  .io_addr(bit_addr),       .sel(sel_bit));

  always_comb begin
    port_rdata = '0;
    ds_rdata   = '0;
    bit_byte   = '0;
    for (int s = 0; s < NSLOT; s++) begin
      port_rdata |= sel_port[s] ? slot_q[s] : '0;
      ds_rdata   |= sel_ds[s]   ? slot_q[s] : '0;
      bit_byte   |= sel_bit[s]  ? slot_q[s] : '0;
    end
  end

  assign bit_val = bit_ok && bit_byte[bit_idx];

  always_comb begin
    wr_sel  = '0;
    wr_mask = '0;
    wr_val  = '0;
    if (bit_wr) begin
      wr_sel  = sel_bit;
      wr_mask = DW'(1) << bit_idx;
      wr_val  = (bit_op == BOP_SET) ? '1 : '0;
    end else if (port_ok && port_we) begin
      wr_sel  = sel_port;
      wr_mask = '1;
      wr_val  = port_wdata;
    end else if (ds_io && ds_we) begin
      wr_sel  = sel_ds;
      wr_mask = '1;
      wr_val  = ds_wdata;
    end
  end

  for (genvar g = 0; g < NGP; g++) begin : g_gp
    io_rs_gpreg #(.DW(DW)) u_gp (
      .clk(clk), .rst_n(rst_n), .we(wr_sel[g]),
      .mask(wr_mask), .val(wr_val), .q(slot_q[g])
    );
    assign gp_flat[g*DW +: DW] = slot_q[g];
  end

  io_rs_w1c #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_n), .we(wr_sel[NGP]),
    .mask(wr_mask), .val(wr_val), .hw_set(flag_set), .q(slot_q[NGP])
  );
  assign st_q = slot_q[NGP];
endmodule

// File: rtl/io_regspace_chk.sv
module io_regspace_chk #(
  parameter int NGP = 3,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_en,
  input logic [7:0]        port_addr,
  input logic              ds_en,
  input logic              bit_en,
  input logic [1:0]        bit_op,
  input logic [5:0]        bit_addr,
  input logic              bit_val,
  input logic [DW-1:0]     flag_set,
  input logic              acc_err,
  input logic [NGP*DW-1:0] gp_flat,
  input logic [DW-1:0]     st_q
);
  AST_PORT_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && port_addr[7:6] != 2'b00) |-> acc_err); // R4

  AST_BITOP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !bit_addr[5] && !bit_op[1]) |=> ($countones(gp_flat ^ $past(gp_flat)) <= 1)); // R5

  AST_BITOP_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && bit_addr[5] && !port_en && !ds_en) |=> $stable(gp_flat)); // R6

  AST_BITOP_BAD_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && bit_addr[5]) |-> (!bit_val && acc_err)); // R6

  AST_HWSET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_set) |=> ((st_q & $past(flag_set)) == $past(flag_set))); // R10
endmodule

bind io_regspace io_regspace_chk #(.NGP(NGP), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .port_addr(port_addr),
  .ds_en(ds_en), .bit_en(bit_en), .bit_op(bit_op), .bit_addr(bit_addr),
  .bit_val(bit_val), .flag_set(flag_set), .acc_err(acc_err),
  .gp_flat(gp_flat), .st_q(st_q)
);

// File: tb/io_regspace_bench.sv
module io_regspace_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 0, port_we = 0;
  logic [7:0] port_addr = 0, port_wdata = 0;
  logic [7:0] port_rdata;
  logic       ds_en = 0, ds_we = 0;
  logic [7:0] ds_addr = 0, ds_wdata = 0;
  logic [7:0] ds_rdata;
  logic       bit_en = 0;
  logic [1:0] bit_op = 0;
  logic [5:0] bit_addr = 0;
  logic [2:0] bit_idx = 0;
  logic       bit_val;
  logic [7:0] flag_set = 0;
  logic       acc_err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_reg [4];

  always #10 clk = ~clk;

  io_regspace u_io_regspace (
    .clk(clk), .rst_n(rst_n),
    .port_en(port_en), .port_we(port_we), .port_addr(port_addr),
    .port_wdata(port_wdata), .port_rdata(port_rdata),
    .ds_en(ds_en), .ds_we(ds_we), .ds_addr(ds_addr),
    .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
    .bit_en(bit_en), .bit_op(bit_op), .bit_addr(bit_addr),
    .bit_idx(bit_idx), .bit_val(bit_val),
    .flag_set(flag_set), .acc_err(acc_err)
  );

  function automatic int slot_of(int a);
    case (a)
      8'h08: return 0;
      8'h09: return 1;
      8'h0A: return 2;
      8'h0C: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int rd(int a);
    int s = slot_of(a);
    return (s < 0) ? 0 : m_reg[s];
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    port_en = 0; port_we = 0; ds_en = 0; ds_we = 0;
    bit_en = 0; flag_set = 0;
  endtask

  task automatic cyc(string tag);
    int e_p, e_d, e_b, e_e, slot, mask, val, clr;
    bit did;
    #1;
    e_p = (port_en && port_addr < 64) ? rd(port_addr) : 0;
    e_d = (ds_en && ds_addr >= 8'h20 && ds_addr < 8'h60) ? rd(ds_addr - 8'h20) : 0;
    e_b = (bit_en && bit_addr < 32) ? ((rd(bit_addr) >> bit_idx) & 1) : 0;
    e_e = ((port_en && port_addr >= 64) || (bit_en && bit_addr >= 32)) ? 1 : 0;
    cmp(tag, "port_rdata", port_rdata, e_p);
    cmp(tag, "ds_rdata", ds_rdata, e_d);
    cmp(tag, "bit_val", bit_val, e_b);
    cmp(tag, "acc_err", acc_err, e_e);
    @(posedge clk);
    did = 1; slot = -1; mask = 0; val = 0; clr = 0;
    if (bit_en && bit_addr < 32 && bit_op < 2) begin
      slot = slot_of(bit_addr); mask = 1 << bit_idx; val = (bit_op == 0) ? 255 : 0;
    end else if (port_en && port_we && port_addr < 64) begin
      slot = slot_of(port_addr); mask = 255; val = port_wdata;
    end else if (ds_en && ds_we && ds_addr >= 8'h20 && ds_addr < 8'h60) begin
      slot = slot_of(ds_addr - 8'h20); mask = 255; val = ds_wdata;
    end else did = 0;
    if (did && slot >= 0 && slot < 3) m_reg[slot] = (m_reg[slot] & ~mask & 255) | (val & mask);
    if (did && slot == 3) clr = mask & val;
    m_reg[3] = ((m_reg[3] & ~clr) | flag_set) & 255;
    @(negedge clk);
  endtask

  task automatic pwr(int a, int d);  idle(); port_en = 1; port_we = 1; port_addr = 8'(a); port_wdata = 8'(d); endtask
  task automatic prd(int a);         idle(); port_en = 1; port_addr = 8'(a); endtask
  task automatic dwr(int a, int d);  idle(); ds_en = 1; ds_we = 1; ds_addr = 8'(a); ds_wdata = 8'(d); endtask
  task automatic drd(int a);         idle(); ds_en = 1; ds_addr = 8'(a); endtask
  task automatic bop(int op, int a, int i); idle(); bit_en = 1; bit_op = 2'(op); bit_addr = 6'(a); bit_idx = 3'(i); endtask

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset values through both maps
    prd(8'h08); cyc("R8"); prd(8'h09); cyc("R8"); prd(8'h0A); cyc("R8"); drd(8'h2C); cyc("R8");
    // R1 and R8: port writes, all bits
    pwr(8'h08, 8'hA5); cyc("R1"); pwr(8'h0A, 8'hFF); cyc("R8");
    prd(8'h08); cyc("R1"); drd(8'h28); cyc("R2"); drd(8'h2A); cyc("R2");
    // R2 load/store write, port read back
    dwr(8'h29, 8'h3C); cyc("R2"); prd(8'h09); cyc("R2");
    // R3 regions outside the I/O window and unmapped I/O
    dwr(8'h09, 8'h11); cyc("R3"); dwr(8'h69, 8'h22); cyc("R3"); dwr(8'hFF, 8'h22); cyc("R3");
    drd(8'h09); cyc("R3"); drd(8'h69); cyc("R3"); pwr(8'h0B, 8'h77); cyc("R3");
    prd(8'h0B); cyc("R3"); prd(8'h09); cyc("R3");
    // R4 port range error
    pwr(8'h48, 8'h00); cyc("R4"); pwr(8'hC9, 8'h00); cyc("R4"); prd(8'h08); cyc("R4"); prd(8'h09); cyc("R4");
    // R5 set and clear of one bit
    bop(0, 8'h09, 0); cyc("R5"); bop(1, 8'h08, 2); cyc("R5"); bop(1, 8'h0A, 7); cyc("R5");
    prd(8'h08); cyc("R5"); prd(8'h09); cyc("R5"); prd(8'h0A); cyc("R5");
    // R7 test reports the bit
    for (int i = 0; i < 8; i++) begin bop(2, 8'h08, i); cyc("R7"); end
    bop(3, 8'h0A, 0); cyc("R7");
    // R6 bit operation out of range
    bop(0, 8'h28, 1); cyc("R6"); bop(1, 8'h3F, 0); cyc("R6"); prd(8'h08); cyc("R6");
    // R9 status write-one-to-clear
    idle(); flag_set = 8'hF3; cyc("R10"); prd(8'h0C); cyc("R10");
    pwr(8'h0C, 8'h30); cyc("R9"); prd(8'h0C); cyc("R9");
    bop(0, 8'h0C, 7); cyc("R9"); bop(1, 8'h0C, 6); cyc("R9"); prd(8'h0C); cyc("R9");
    dwr(8'h2C, 8'h02); cyc("R9"); drd(8'h2C); cyc("R9");
    // R10 set wins over clear in the same cycle
    pwr(8'h0C, 8'hFF); flag_set = 8'h40; cyc("R10"); prd(8'h0C); cyc("R10");
    bop(0, 8'h0C, 6); flag_set = 8'h40; cyc("R10"); prd(8'h0C); cyc("R10");
    // R11 priority among simultaneous writes
    pwr(8'h08, 8'h55); ds_en = 1; ds_we = 1; ds_addr = 8'h28; ds_wdata = 8'hAA; cyc("R11");
    prd(8'h08); cyc("R11");
    bop(0, 8'h08, 7); port_en = 1; port_we = 1; port_addr = 8'h08; port_wdata = 8'h00; cyc("R11");
    prd(8'h08); cyc("R11");
    bop(2, 8'h09, 1); port_en = 1; port_we = 1; port_addr = 8'h09; port_wdata = 8'h81; cyc("R11");
    prd(8'h09); cyc("R11");
    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      idle();
      port_en = 1'($urandom); port_we = 1'($urandom);
      port_addr = ($urandom % 4 == 0) ? 8'($urandom) : 8'(8 + $urandom % 6);
      port_wdata = 8'($urandom);
      ds_en = 1'($urandom); ds_we = 1'($urandom);
      ds_addr = ($urandom % 4 == 0) ? 8'($urandom) : 8'(8'h28 + $urandom % 6);
      ds_wdata = 8'($urandom);
      bit_en = 1'($urandom); bit_op = 2'($urandom); bit_idx = 3'($urandom);
      bit_addr = ($urandom % 4 == 0) ? 6'($urandom) : 6'(8 + $urandom % 6);
      flag_set = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      cyc("R11");
    end
    idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule